// File: doc/BRIEF.md
# Unlock-Sequence Command Detector

This block sits beside a byte-wide memory and watches the accesses made to it. An access is counted once per falling edge of the active-low chip enable. The edge is resynchronised onto the system clock, and the address and write strobe are sampled when the edge is detected. A host issues a nonvolatile STORE or RECALL command by reading six particular addresses back to back. The first five addresses are the same for both commands, and the sixth decides which command is issued. Any other access in the middle of the run, whether a read of another address or any write, drops the run without issuing anything.

The state machine has six named states:
- `ST_IDLE` (position 0): no part of the sequence has been seen.
- `ST_HIT1` to `ST_HIT5` (positions 1 to 5): that many leading addresses of the sequence have been matched.

The transitions are:
- *advance*: a read of the expected address for the current state moves to the next state.
- *issue*: a read of the STORE or RECALL address in `ST_HIT5` raises the matching request pulse for one cycle and returns to `ST_IDLE`.
- *restart*: a read of some other address that equals the first address of the sequence goes to `ST_HIT1`.
- *abort*: any write, or any other read, goes to `ST_IDLE`.

The current position is available on an output.

Top module: `nv_seq_detect`

## Requirements
- R1: After reset the position output is 0 and neither request pulse is high.
- R2: Only address bits 13:0 are compared; address bit 14 has no effect on matching.
- R3: Reads of 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, in that order with the write strobe high, move the position through 1, 2, 3, 4 and 5.
- R4: In position 5, a read of 0x0FC0 gives a one-cycle store request and returns the position to 0.
- R5: In position 5, a read of 0x0C63 gives a one-cycle recall request and returns the position to 0.
- R6: An access with the write strobe low returns the position to 0 and issues no request, even if its address is one of the sequence addresses.
- R7: A read that does not match the expected address aborts the run with no request. If that read is 0x0E38 the position becomes 1; otherwise it becomes 0.
- R8: Store and recall requests are never high together. Each request lasts exactly one clock cycle, and the request goes high on the third rising clock edge after chip enable falls.
- R9: Chip enable held low counts as a single access. Only a new falling edge is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable, asynchronous to clk |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 15 | Memory address |
| store_req | output | 1 | One-cycle STORE command pulse |
| recall_req | output | 1 | One-cycle RECALL command pulse |
| seq_pos | output | 3 | Number of sequence addresses matched so far |

## Verification
Two functions can fall on the same edge. The first case is abort and restart: a read of 0x0E38 that arrives in the middle of a run both ends the run and starts a new one. It is provoked in position 3 and in position 5, and it is judged by the position reading 1 with no request pulse. The second case is the issue of a command together with the return to idle. It is judged by the scoreboard receiving exactly one pulse of the right kind and, on the same access, the position reading 0.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    localparam int ADDR_W = 15;
    localparam int CMP_W  = 14;
    localparam int STEPS  = 5;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HIT1 = 3'd1,
        ST_HIT2 = 3'd2,
        ST_HIT3 = 3'd3,
        ST_HIT4 = 3'd4,
        ST_HIT5 = 3'd5
    } seq_state_t;

    localparam logic [CMP_W-1:0] KEY_STORE  = 14'h0FC0;
    localparam logic [CMP_W-1:0] KEY_RECALL = 14'h0C63;

    // Expected prefix address for a given step (0 = first).
    function automatic logic [CMP_W-1:0] prefix_key(input logic [2:0] step);
        logic [CMP_W-1:0] k;
        case (step)
            3'd0:    k = 14'h0E38;
            3'd1:    k = 14'h31C7;
            3'd2:    k = 14'h03E0;
            3'd3:    k = 14'h3C1F;
            3'd4:    k = 14'h303F;
            default: k = '1;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/nvseq_edge.sv
module nvseq_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    output logic ce_fall
);
    logic [SYNC_N:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[SYNC_N-1:0], ce_n};
    end

    assign ce_fall = sh_q[SYNC_N] & ~sh_q[SYNC_N-1];
endmodule

// File: rtl/nvseq_match.sv
module nvseq_match
    import nvseq_pkg::*;
(
    input  logic [CMP_W-1:0] key,
    input  seq_state_t       state,
    output logic             hit_next,
    output logic             hit_first,
    output logic             hit_store,
    output logic             hit_recall
);
    logic in_last;

    assign in_last    = (state == ST_HIT5);
    assign hit_next   = !in_last && (key == prefix_key(state));
    assign hit_first  = (key == prefix_key(3'd0));
    assign hit_store  = in_last && (key == KEY_STORE);
    assign hit_recall = in_last && (key == KEY_RECALL);
endmodule

// File: rtl/nv_seq_detect.sv
module nv_seq_detect
    import nvseq_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              store_req,
    output logic              recall_req,
    output logic [2:0]        seq_pos
);
    seq_state_t state_q, state_d;
    logic ev, hit_next, hit_first, hit_store, hit_recall;
    logic rd_ev;

    nvseq_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .ce_fall(ev)
    );

    nvseq_match u_match (
        .key       (addr[CMP_W-1:0]),
        .state     (state_q),
        .hit_next  (hit_next),
        .hit_first (hit_first),
        .hit_store (hit_store),
        .hit_recall(hit_recall)
    );

    assign rd_ev = ev && we_n;

    always_comb begin
        state_d = state_q;
        if (ev) begin
            if (!we_n) begin
                state_d = ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE, ST_HIT1, ST_HIT2, ST_HIT3, ST_HIT4: begin
                        if (hit_next)       state_d = seq_state_t'(state_q + 3'd1);
                        else if (hit_first) state_d = ST_HIT1;
                        else                state_d = ST_IDLE;
                    end
                    ST_HIT5: begin
                        if (hit_store || hit_recall) state_d = ST_IDLE;
                        else if (hit_first)          state_d = ST_HIT1;
                        else                         state_d = ST_IDLE;
                    end
                    default: state_d = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_req  <= 1'b0;
            recall_req <= 1'b0;
        end else begin
            store_req  <= rd_ev && hit_store;
            recall_req <= rd_ev && hit_recall;
        end
    end

    assign seq_pos = state_q;
endmodule

// File: rtl/nv_seq_detect_chk.sv
module nv_seq_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       store_req,
    input logic       recall_req,
    input logic [2:0] seq_pos
);
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req));

    p_store_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);

    p_recall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req);

    p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_pos <= 3'd5);

    p_store_from_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_req) |-> ($past(seq_pos) == 3'd5 && seq_pos == 3'd0));

    p_recall_from_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recall_req) |-> ($past(seq_pos) == 3'd5 && seq_pos == 3'd0));

    p_pos_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_pos != $past(seq_pos)) |->
            (seq_pos == 3'd0 || seq_pos == 3'd1 || seq_pos == $past(seq_pos) + 3'd1));
endmodule

bind nv_seq_detect nv_seq_detect_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .store_req (store_req),
    .recall_req(recall_req),
    .seq_pos   (seq_pos)
);

// File: tb/nv_seq_detect_bench.sv
module nv_seq_detect_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [14:0] addr = '0;
    logic        store_req, recall_req;
    logic [2:0]  seq_pos;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [1:0] exp_q[$];   // 1 = store, 2 = recall

    always #10 clk = ~clk;

    nv_seq_detect u_nv_seq_detect (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .store_req(store_req), .recall_req(recall_req), .seq_pos(seq_pos)
    );

    // Monitor: every pulse must match the scoreboard head (R4, R5, R8, R9)
    always @(negedge clk) begin
        if (rst_n && (store_req || recall_req)) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R9 unexpected pulse: actual=%b%b expected=none", recall_req, store_req);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                if ({recall_req, store_req} != e) begin
                    bad++;
                    $display("FAIL R8 pulse kind: actual=%b%b expected=%b", recall_req, store_req, e);
                end
            end
        end
    end

    task automatic access(input logic [14:0] a, input logic w_n, input logic [2:0] exp_pos,
                          input string req);
        addr = a;
        we_n = w_n;
        @(negedge clk);
        ce_n = 1'b0;
        repeat (5) @(negedge clk);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
        total++;
        if (seq_pos != exp_pos) begin
            bad++;
            $display("FAIL %s addr=%h: actual pos=%0d expected=%0d", req, a, seq_pos, exp_pos);
        end
    endtask

    task automatic prefix(input int n, input logic b14, input string req);
        logic [13:0] keys [5];
        keys = '{14'h0E38, 14'h31C7, 14'h03E0, 14'h3C1F, 14'h303F};
        for (int i = 0; i < n; i++)
            access({b14, keys[i]}, 1'b1, 3'(i + 1), req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (seq_pos != 0 || store_req || recall_req) begin
            bad++;
            $display("FAIL R1 reset: actual pos=%0d st=%b rc=%b expected=0 0 0", seq_pos, store_req, recall_req);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        total++;
        if (seq_pos != 0) begin
            bad++;
            $display("FAIL R1 after release: actual=%0d expected=0", seq_pos);
        end

        // R3/R4 full store
        prefix(5, 1'b0, "R3");
        exp_q.push_back(2'b01);
        access(15'h0FC0, 1'b1, 3'd0, "R4");

        // R2/R5 recall with bit 14 set
        prefix(5, 1'b1, "R2");
        exp_q.push_back(2'b10);
        access(15'h4C63, 1'b1, 3'd0, "R5");

        // R6 write aborts
        prefix(2, 1'b0, "R3");
        access(15'h03E0, 1'b0, 3'd0, "R6");
        access(15'h0E38, 1'b0, 3'd0, "R6");
        prefix(5, 1'b0, "R3");
        access(15'h0FC0, 1'b0, 3'd0, "R6");

        // R7 mismatched read aborts / restart
        prefix(2, 1'b0, "R3");
        access(15'h1234, 1'b1, 3'd0, "R7");
        prefix(3, 1'b0, "R3");
        access(15'h0E38, 1'b1, 3'd1, "R7");
        access(15'h31C7, 1'b1, 3'd2, "R7");
        access(15'h03E0, 1'b1, 3'd3, "R7");
        access(15'h3C1F, 1'b1, 3'd4, "R7");
        access(15'h303F, 1'b1, 3'd5, "R7");
        exp_q.push_back(2'b01);
        access(15'h0FC0, 1'b1, 3'd0, "R4");

        // R7 restart from position 5, then near-miss sixth address
        prefix(5, 1'b0, "R3");
        access(15'h0E38, 1'b1, 3'd1, "R7");
        prefix(5, 1'b0, "R3");
        access(15'h0FC1, 1'b1, 3'd0, "R7");

        // R9 long low chip enable counts once
        prefix(5, 1'b0, "R3");
        exp_q.push_back(2'b10);
        addr = 15'h0C63; we_n = 1'b1;
        @(negedge clk); ce_n = 1'b0;
        repeat (40) @(negedge clk);
        total++;
        if (seq_pos != 0) begin
            bad++;
            $display("FAIL R9 held low: actual pos=%0d expected=0", seq_pos);
        end
        ce_n = 1'b1;
        repeat (5) @(negedge clk);

        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R8 missing pulses: actual=0 expected=%0d", exp_q.size());
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule